// File: doc/BRIEF.md
# Keyboard-Link Host Transmitter

This block is the controller end of a two-wire open-drain keyboard link. The link has one clock line and one data line. Either side may pull a line low, and a line that nobody pulls floats high. The block sends one command byte to the attached device. It first holds the clock line low so that the device cannot start a transfer. With the clock still held, it pulls the data line low to ask for the link. It then lets go of the clock, and from that point the device generates every clock pulse. The host places one new frame bit on the data line after each falling edge the device makes. The device's eleventh falling edge carries the device's own answer on the data line, and the host reads that level as the acknowledge. After that edge the host pulls the clock low again, which leaves the link inhibited.

Both line levels are first passed through a synchronizer and then a majority-free window filter, so short glitches on a noisy cable do not move the frame forward. A counter sets the length of the opening inhibit and of the request phase. The same counter guards every wait for a device edge and ends a stalled transfer with an error. An abort request releases the link at once, even in the middle of a frame.

Top module: `kbd_host_tx`

## Requirements
- R1: After reset and whenever no transfer is running, `clk_drive_low` is 1 (clock held low), `dat_drive_low` is 0, `busy` is 0 and `done` is 0. `ack_ok` and `timeout_err` are 0 after reset.
- R2: When `tx_start` is 1 while idle, `busy` rises on the next edge. The host then keeps the clock held low with data released for exactly INHIBIT_CYCLES clock cycles.
- R3: After the inhibit, the host pulls data low while still holding the clock for REQ_CYCLES cycles. It then releases the clock and keeps data low, which forms the start bit.
- R4: After the n-th device falling edge the host presents frame bit n on data, where 1 means released. Bits 1 to 8 are `tx_byte` bit 0 through bit 7. Bit 9 is odd parity, equal to 1 when the byte holds an even number of ones. Bit 10 is the stop bit, which is always 1.
- R5: Each line is synchronized through SYNC_STAGES flops and then filtered. A filtered level changes only after FILT_LEN consecutive equal samples, so a low pulse shorter than FILT_LEN cycles is ignored. The host reacts to a clean clock fall on the edge that comes SYNC_STAGES+FILT_LEN edges after the first edge that samples the low level.
- R6: On the eleventh device falling edge the host reads filtered data. `ack_ok` becomes 1 if data is low and 0 if it is high. On the same edge `done` pulses for one cycle, `busy` falls and the clock is held low again.
- R7: Once the clock has been released, if TIMEOUT_CYCLES cycles pass with no device falling edge, then `timeout_err` becomes 1, `done` pulses, `ack_ok` stays 0 and the host returns to the inhibited idle state.
- R8: `abort_req` while busy returns the block to the idle inhibited state on the next edge, and `done` does not pulse.
- R9: `tx_start` while busy is ignored. The byte being sent is not replaced.
- R10: `ack_ok` and `timeout_err` hold their values after a transfer ends, until the next accepted `tx_start` clears both. They are never both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| link_clk_in | input | 1 | Sampled level of the shared clock line |
| link_dat_in | input | 1 | Sampled level of the shared data line |
| tx_byte | input | 8 | Command byte, captured when a send is accepted |
| tx_start | input | 1 | Send request, taken only while idle |
| abort_req | input | 1 | Abandon the running transfer |
| clk_drive_low | output | 1 | 1 pulls the clock line low |
| dat_drive_low | output | 1 | 1 pulls the data line low |
| busy | output | 1 | A transfer is in progress |
| done | output | 1 | One-cycle pulse when a transfer completes or times out |
| ack_ok | output | 1 | Device acknowledged the last transfer |
| timeout_err | output | 1 | Last transfer stalled waiting for a device edge |

## Verification
The hardest case to reach is a clock glitch in the middle of a frame. If the block counted that glitch as a device edge, every later bit would shift by one position, and this only shows up in the bits the device captures and in when the transfer finishes. The bench device model inserts a low pulse of FILT_LEN-1 cycles into a high phase of its clock. It then checks the byte, parity and stop bit it received, and it checks that the host waits for a genuine eleventh edge. Stalls are reached by a device that never clocks and by one that stops after five edges. The abort case is reached by pulsing the request in the middle of a frame.

// File: rtl/kbd_tx_pkg.sv
package kbd_tx_pkg;

   localparam int DATA_W     = 8;
   localparam int FRAME_BITS = DATA_W + 3;   // start, data, parity, stop
   localparam int LAST_FALL  = FRAME_BITS - 1;

   typedef enum logic [1:0] {
      ST_HOLD,
      ST_INHIB,
      ST_REQ,
      ST_SHIFT
   } tx_state_e;

   // odd parity: the bit that makes the total count of ones odd
   function automatic logic odd_par(input logic [DATA_W-1:0] b);
      return ~(^b);
   endfunction

endpackage

// File: rtl/kbd_line_filter.sv
module kbd_line_filter #(
   parameter int   SYNC_STAGES = 2,
   parameter int   FILT_LEN    = 3,
   parameter logic IDLE_LEVEL  = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic raw,
   output logic q
);

   initial begin
      assert (SYNC_STAGES >= 2) else $fatal(1, "line filter needs two or more sync stages");
      assert (FILT_LEN >= 1)    else $fatal(1, "line filter window must be at least one");
   end

   logic [SYNC_STAGES-1:0] sync_r;
   logic                   s_last;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_r <= {SYNC_STAGES{IDLE_LEVEL}};
      else        sync_r <= {sync_r[SYNC_STAGES-2:0], raw};
   end

   assign s_last = sync_r[SYNC_STAGES-1];

   generate
      if (FILT_LEN == 1) begin : g_pass
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q <= IDLE_LEVEL;
            else        q <= s_last;
         end
      end else begin : g_window
         logic [FILT_LEN-2:0] hist;
         logic [FILT_LEN-1:0] window;

         assign window = {hist, s_last};

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               hist <= {(FILT_LEN-1){IDLE_LEVEL}};
               q    <= IDLE_LEVEL;
            end else begin
               hist <= window[FILT_LEN-2:0];
               if (&window)       q <= 1'b1;
               else if (~|window) q <= 1'b0;
            end
         end
      end
   endgenerate

endmodule

// File: rtl/kbd_tx_timer.sv
module kbd_tx_timer #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   output logic [W-1:0] count
);

   initial assert (W >= 1) else $fatal(1, "timer width must be positive");

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   count <= '0;
      else if (clr) count <= '0;
      else          count <= count + W'(1);
   end

endmodule

// File: rtl/kbd_tx_frame.sv
module kbd_tx_frame
   import kbd_tx_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [DATA_W-1:0] data_in,
   input  logic              shift,
   output logic              bit_out
);

   logic [FRAME_BITS-1:0] sh;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     sh <= '1;
      else if (load)  sh <= {1'b1, odd_par(data_in), data_in, 1'b0};
      else if (shift) sh <= {1'b1, sh[FRAME_BITS-1:1]};
   end

   assign bit_out = sh[0];

endmodule

// File: rtl/kbd_host_tx.sv
module kbd_host_tx
   import kbd_tx_pkg::*;
#(
   parameter int SYNC_STAGES    = 2,
   parameter int FILT_LEN       = 3,
   parameter int INHIBIT_CYCLES = 25000,     // 100 us at 250 MHz
   parameter int REQ_CYCLES     = 4,
   parameter int TIMEOUT_CYCLES = 3750000    // 15 ms at 250 MHz
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              link_clk_in,
   input  logic              link_dat_in,
   input  logic [DATA_W-1:0] tx_byte,
   input  logic              tx_start,
   input  logic              abort_req,
   output logic              clk_drive_low,
   output logic              dat_drive_low,
   output logic              busy,
   output logic              done,
   output logic              ack_ok,
   output logic              timeout_err
);

   localparam int LIM_AB   = (INHIBIT_CYCLES > REQ_CYCLES) ? INHIBIT_CYCLES : REQ_CYCLES;
   localparam int LIM_MAX  = (LIM_AB > TIMEOUT_CYCLES) ? LIM_AB : TIMEOUT_CYCLES;
   localparam int CNT_W    = $clog2(LIM_MAX + 1);
   localparam int FALL_W   = $clog2(FRAME_BITS + 1);
   localparam int N_LINES  = 2;
   localparam int L_CLK    = 0;
   localparam int L_DAT    = 1;

   localparam logic [CNT_W-1:0]  INH_LAST  = CNT_W'(INHIBIT_CYCLES - 1);
   localparam logic [CNT_W-1:0]  REQ_LAST  = CNT_W'(REQ_CYCLES - 1);
   localparam logic [CNT_W-1:0]  TO_LAST   = CNT_W'(TIMEOUT_CYCLES - 1);
   localparam logic [FALL_W-1:0] FALL_DONE = FALL_W'(LAST_FALL);

   initial begin
      assert (INHIBIT_CYCLES >= 1) else $fatal(1, "inhibit length must be positive");
      assert (REQ_CYCLES >= 1)     else $fatal(1, "request length must be positive");
      assert (TIMEOUT_CYCLES >= 2) else $fatal(1, "timeout must exceed one cycle");
   end

   // ---------------- line conditioning ----------------
   logic [N_LINES-1:0] line_raw;
   logic [N_LINES-1:0] line_q;

   assign line_raw = {link_dat_in, link_clk_in};

   generate
      for (genvar i = 0; i < N_LINES; i++) begin : g_line
         kbd_line_filter #(
            .SYNC_STAGES (SYNC_STAGES),
            .FILT_LEN    (FILT_LEN),
            .IDLE_LEVEL  (1'b1)
         ) u_filt (
            .clk   (clk),
            .rst_n (rst_n),
            .raw   (line_raw[i]),
            .q     (line_q[i])
         );
      end
   endgenerate

   logic clk_q_d;
   logic dev_fall;

   assign dev_fall = clk_q_d & ~line_q[L_CLK];

   // ---------------- control ----------------
   tx_state_e         state, state_nxt;
   logic [CNT_W-1:0]  tcount;
   logic [FALL_W-1:0] nfall;
   logic              tmr_clr;
   logic              ld, shf, fin_ok, fin_to;
   logic              bit_out;
   logic              done_r, ack_r, err_r;

   always_comb begin
      state_nxt = state;
      ld        = 1'b0;
      shf       = 1'b0;
      fin_ok    = 1'b0;
      fin_to    = 1'b0;
      unique case (state)
         ST_HOLD: begin
            if (tx_start) begin
               state_nxt = ST_INHIB;
               ld        = 1'b1;
            end
         end
         ST_INHIB: begin
            if (abort_req)               state_nxt = ST_HOLD;
            else if (tcount == INH_LAST) state_nxt = ST_REQ;
         end
         ST_REQ: begin
            if (abort_req)               state_nxt = ST_HOLD;
            else if (tcount == REQ_LAST) state_nxt = ST_SHIFT;
         end
         ST_SHIFT: begin
            if (abort_req) begin
               state_nxt = ST_HOLD;
            end else if (dev_fall) begin
               shf = 1'b1;
               if (nfall == FALL_DONE) begin
                  fin_ok    = 1'b1;
                  state_nxt = ST_HOLD;
               end
            end else if (tcount == TO_LAST) begin
               fin_to    = 1'b1;
               state_nxt = ST_HOLD;
            end
         end
         default: state_nxt = ST_HOLD;
      endcase
   end

   assign tmr_clr = (state_nxt != state) | (state == ST_HOLD) | shf;

   kbd_tx_timer #(.W(CNT_W)) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (tmr_clr),
      .count (tcount)
   );

   kbd_tx_frame u_frame (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (ld),
      .data_in (tx_byte),
      .shift   (shf),
      .bit_out (bit_out)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_HOLD;
         nfall   <= '0;
         clk_q_d <= 1'b1;
         done_r  <= 1'b0;
         ack_r   <= 1'b0;
         err_r   <= 1'b0;
      end else begin
         state   <= state_nxt;
         clk_q_d <= line_q[L_CLK];
         done_r  <= fin_ok | fin_to;
         if (state != ST_SHIFT) nfall <= '0;
         else if (shf)          nfall <= nfall + FALL_W'(1);
         if (ld)          ack_r <= 1'b0;
         else if (fin_ok) ack_r <= ~line_q[L_DAT];
         if (ld)          err_r <= 1'b0;
         else if (fin_to) err_r <= 1'b1;
      end
   end

   assign clk_drive_low = (state != ST_SHIFT);
   assign dat_drive_low = (state == ST_REQ) | ((state == ST_SHIFT) & ~bit_out);
   assign busy          = (state != ST_HOLD);
   assign done          = done_r;
   assign ack_ok        = ack_r;
   assign timeout_err   = err_r;

endmodule

// File: rtl/kbd_host_tx_chk.sv
module kbd_host_tx_chk (
   input logic clk,
   input logic rst_n,
   input logic tx_start,
   input logic abort_req,
   input logic clk_drive_low,
   input logic dat_drive_low,
   input logic busy,
   input logic done,
   input logic ack_ok,
   input logic timeout_err
);

   p_idle_inhibit_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> clk_drive_low && !dat_drive_low);

   p_inhibit_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> clk_drive_low && !dat_drive_low);

   p_request_before_release_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(clk_drive_low) |-> $past(dat_drive_low) && dat_drive_low);

   p_done_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   p_done_ends_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy && $past(busy));

   p_timeout_with_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(timeout_err) |-> done);

   p_abort_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
      busy && abort_req |=> !busy && !done);

   p_start_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !busy && tx_start |=> busy && !ack_ok && !timeout_err);

   p_flags_exclusive_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !(ack_ok && timeout_err));

endmodule

bind kbd_host_tx kbd_host_tx_chk u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .tx_start      (tx_start),
   .abort_req     (abort_req),
   .clk_drive_low (clk_drive_low),
   .dat_drive_low (dat_drive_low),
   .busy          (busy),
   .done          (done),
   .ack_ok        (ack_ok),
   .timeout_err   (timeout_err)
);

// File: tb/kbd_host_tx_test.sv
module kbd_host_tx_test;

   localparam int SYNC = 2;
   localparam int FILT = 3;
   localparam int INH  = 40;
   localparam int REQH = 4;
   localparam int TO   = 300;
   localparam int HALF = 15;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       dev_clk = 1'b1;
   logic       dev_dat = 1'b1;
   logic       tx_start = 1'b0;
   logic       abort_req = 1'b0;
   logic [7:0] tx_byte = 8'h00;
   logic       clk_drive_low, dat_drive_low, busy, done, ack_ok, timeout_err;
   logic       link_clk_in, link_dat_in;

   // open-drain wired AND of host and device drivers
   assign link_clk_in = dev_clk & ~clk_drive_low;
   assign link_dat_in = dev_dat & ~dat_drive_low;

   always #2 clk = ~clk;

   kbd_host_tx #(
      .SYNC_STAGES    (SYNC),
      .FILT_LEN       (FILT),
      .INHIBIT_CYCLES (INH),
      .REQ_CYCLES     (REQH),
      .TIMEOUT_CYCLES (TO)
   ) uut (
      .clk           (clk),
      .rst_n         (rst_n),
      .link_clk_in   (link_clk_in),
      .link_dat_in   (link_dat_in),
      .tx_byte       (tx_byte),
      .tx_start      (tx_start),
      .abort_req     (abort_req),
      .clk_drive_low (clk_drive_low),
      .dat_drive_low (dat_drive_low),
      .busy          (busy),
      .done          (done),
      .ack_ok        (ack_ok),
      .timeout_err   (timeout_err)
   );

   int checks = 0;
   int fails  = 0;
   bit finished = 1'b0;

   task automatic chk(input string tag, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
      end
   endtask

   // ---------------- behavioural reference model ----------------
   int         m_ph;      // 0 idle, 1 inhibit, 2 request, 3 shifting
   int         m_cnt;
   int         m_nf;
   logic [7:0] m_byte;
   bit         m_done, m_ack, m_err;
   logic [31:0] rc, rd;
   bit         fc1, fc2, fd1, m_fall, m_dsam;

   function automatic bit filt_level(input logic [31:0] h, input bit prev);
      logic [31:0] mask, w;
      mask = (32'd1 << FILT) - 32'd1;
      w    = (h >> SYNC) & mask;
      if (w == 32'd0) return 1'b0;
      if (w == mask)  return 1'b1;
      return prev;
   endfunction

   function automatic bit frame_bit(input int p, input logic [7:0] b);
      if (p == 0) return 1'b0;
      if (p <= 8) return b[p-1];
      if (p == 9) return ~(^b);
      return 1'b1;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_ph = 0; m_cnt = 0; m_nf = 0; m_byte = 8'h00;
         m_done = 0; m_ack = 0; m_err = 0;
         rc = '1; rd = '1; fc1 = 1; fc2 = 1; fd1 = 1;
      end else begin
         m_fall = fc2 & ~fc1;
         m_dsam = fd1;
         rc  = {rc[30:0], link_clk_in};
         rd  = {rd[30:0], link_dat_in};
         fc2 = fc1;
         fc1 = filt_level(rc, fc1);
         fd1 = filt_level(rd, fd1);
         m_done = 0;
         case (m_ph)
            0: if (tx_start) begin
                  m_ph = 1; m_cnt = 0; m_byte = tx_byte; m_ack = 0; m_err = 0;
               end
            1: if (abort_req) m_ph = 0;
               else if (m_cnt == INH - 1) begin m_ph = 2; m_cnt = 0; end
               else m_cnt++;
            2: if (abort_req) m_ph = 0;
               else if (m_cnt == REQH - 1) begin m_ph = 3; m_cnt = 0; m_nf = 0; end
               else m_cnt++;
            default: begin
               if (abort_req) m_ph = 0;
               else if (m_fall) begin
                  if (m_nf == 10) begin m_ack = ~m_dsam; m_done = 1; m_ph = 0; end
                  else begin m_nf++; m_cnt = 0; end
               end else if (m_cnt == TO - 1) begin
                  m_err = 1; m_done = 1; m_ph = 0;
               end else m_cnt++;
            end
         endcase
      end
   end

   always @(negedge clk) begin
      if (rst_n) begin
         chk("R2 R3", "clk_drive_low", clk_drive_low, (m_ph != 3));
         chk("R4", "dat_drive_low", dat_drive_low,
             (m_ph == 2) || (m_ph == 3 && !frame_bit(m_nf, m_byte)));
         chk("R2", "busy", busy, (m_ph != 0));
         chk("R6", "done", done, m_done);
         chk("R10", "ack_ok", ack_ok, m_ack);
         chk("R7", "timeout_err", timeout_err, m_err);
      end
   end

   // ---------------- device and host helpers ----------------
   bit saw_done, done_ack, done_err;

   task automatic start_tx(input logic [7:0] b);
      tx_byte  = b;
      tx_start = 1'b1;
      @(negedge clk);
      tx_start = 1'b0;
   endtask

   task automatic wait_done();
      int n = 0;
      saw_done = 0;
      while (!done && n < 5000) begin
         @(negedge clk);
         n++;
      end
      if (done) begin
         saw_done = 1; done_ack = ack_ok; done_err = timeout_err;
      end
   endtask

   task automatic device(input int nfall, input bit give_ack, input int glitch_after,
                         output logic [9:0] rx);
      int guard = 0;
      rx = '0;
      while (clk_drive_low && guard < 2000) begin
         @(negedge clk);
         guard++;
      end
      chk("R3", "start bit on data at clock release", link_dat_in, 0);
      repeat (HALF) @(negedge clk);
      for (int i = 1; i <= nfall; i++) begin
         if (i == 11 && give_ack) begin
            dev_dat = 1'b0;
            repeat (3) @(negedge clk);
         end
         dev_clk = 1'b0;
         repeat (HALF) @(negedge clk);
         if (i <= 10) rx[i-1] = link_dat_in;
         dev_clk = 1'b1;
         if (i == glitch_after) begin
            repeat (5) @(negedge clk);
            dev_clk = 1'b0;
            repeat (FILT - 1) @(negedge clk);
            dev_clk = 1'b1;
            repeat (HALF) @(negedge clk);
         end else begin
            repeat (HALF) @(negedge clk);
         end
      end
      dev_dat = 1'b1;
   endtask

   // ---------------- stimulus ----------------
   logic [9:0] rx;

   initial begin
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", "reset clk_drive_low", clk_drive_low, 1);
      chk("R1", "reset dat_drive_low", dat_drive_low, 0);
      chk("R1", "reset busy", busy, 0);
      chk("R1", "reset flags", {done, ack_ok, timeout_err}, 0);
      repeat (10) @(negedge clk);

      // A: acknowledged transfer
      start_tx(8'hA5);
      chk("R2", "busy after start", busy, 1);
      chk("R2", "inhibit with data released", {clk_drive_low, dat_drive_low}, 2);
      fork
         device(11, 1'b1, 0, rx);
         wait_done();
      join
      chk("R4", "received byte A5", rx[7:0], 8'hA5);
      chk("R4", "parity of A5", rx[8], 1);
      chk("R4", "stop bit", rx[9], 1);
      chk("R6", "done seen", saw_done, 1);
      chk("R6", "ack on completion", done_ack, 1);
      chk("R6", "clock re-held after frame", clk_drive_low, 1);
      repeat (50) @(negedge clk);
      chk("R10", "ack held while idle", ack_ok, 1);

      // B: no acknowledge, clock glitch mid-frame
      start_tx(8'h00);
      chk("R10", "start clears ack", ack_ok, 0);
      fork
         device(11, 1'b0, 3, rx);
         wait_done();
      join
      chk("R5", "glitch ignored, byte 00", rx[7:0], 8'h00);
      chk("R5", "glitch ignored, parity", rx[8], 1);
      chk("R6", "no ack when data high", done_ack, 0);
      chk("R6", "done after 11 real edges", saw_done, 1);

      // C: start ignored while busy
      fork
         begin
            start_tx(8'h3C);
         end
      join
      fork
         device(11, 1'b1, 0, rx);
         wait_done();
         begin
            repeat (150) @(negedge clk);
            start_tx(8'hFF);
         end
      join
      chk("R9", "byte kept despite second start", rx[7:0], 8'h3C);
      chk("R9", "parity of 3C", rx[8], 1);
      chk("R6", "ack on third frame", done_ack, 1);
      repeat (20) @(negedge clk);

      // D: device never clocks
      start_tx(8'h11);
      wait_done();
      chk("R7", "timeout with no clocking", done_err, 1);
      chk("R7", "no ack on timeout", done_ack, 0);
      chk("R7", "idle after timeout", busy, 0);
      repeat (30) @(negedge clk);
      chk("R10", "timeout flag held", timeout_err, 1);

      // E: device stops mid-frame
      start_tx(8'h7E);
      chk("R10", "start clears timeout flag", timeout_err, 0);
      fork
         device(5, 1'b0, 0, rx);
         wait_done();
      join
      chk("R7", "timeout after stalled frame", done_err, 1);
      repeat (20) @(negedge clk);

      // F: abort mid-frame
      start_tx(8'h5A);
      device(3, 1'b0, 0, rx);
      abort_req = 1'b1;
      @(negedge clk);
      abort_req = 1'b0;
      chk("R8", "idle after abort", busy, 0);
      chk("R8", "clock held after abort", clk_drive_low, 1);
      chk("R8", "no done on abort", done, 0);
      for (int k = 0; k < 20; k++) begin
         @(negedge clk);
         chk("R8", "done stays low after abort", done, 0);
      end

      // G: abort during inhibit
      start_tx(8'hC3);
      repeat (10) @(negedge clk);
      abort_req = 1'b1;
      @(negedge clk);
      abort_req = 1'b0;
      chk("R8", "abort during inhibit", busy, 0);
      repeat (20) @(negedge clk);

      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         fails++;
         $display("FAIL watchdog all requirements actual=running expected=finished");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

endmodule